// File: doc/BRIEF.md
# Serial Johnson Codeword Generator

This block produces the single-input-change (Johnson) codewords of an l-bit ring without storing an l-bit ring. It serialises each codeword into a short shift register whose width equals the number of scan chains. A run counter records how many leading bits of the next codeword differ from the trailing bits. A second counter meters that run out, one bit per shift clock, and the fill bit is chosen from this count and a half-sequence phase flag.

The block is driven by a single scan-enable input. Each clock with scan-enable low prepares the next codeword and leaves the register untouched. Each clock with scan-enable high shifts one codeword bit into the register, leading bit first. A test controller normally gives one low clock and then l high clocks per codeword, and XORs the register contents with seed bits outside this block.

Top module: `scalable_sic_counter`

## Requirements
- R1: An active-low reset clears the shift register to all zeros and makes codeword index 0 the next one loaded. Before any load, shifting inserts zeros.
- R2: A clock with scan_en=0 leaves chain_word unchanged, loads the next codeword, and advances the codeword index by exactly one.
- R3: A clock with scan_en=1 moves chain_word[i] to chain_word[i+1], drops the old top bit, and places the new codeword bit in chain_word[0].
- R4: For a codeword index i below l, the bit shifted at shift position j (0-based) is 1 when j < i and 0 otherwise.
- R5: For a codeword index i from l to 2l-1, the bit at shift position j is 0 when j < i-l and 1 otherwise.
- R6: After index 2l-1, the index wraps to 0.
- R7: When scan_en stays high past l shifts, the shifted bit holds at the trailing value of the current codeword: 0 in the first half, 1 in the second half.
- R8: The l bits shifted for codeword i, read first-shifted as most significant, equal state i of an l-bit Johnson ring started at zero that feeds the inverse of its last bit into its first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | 1: shift one codeword bit; 0: load the next codeword |
| chain_word | output | NUM_CHAINS | Shift register contents; bit 0 is the newest bit |

## Verification
A wrong run counter or a stale load does not appear when it happens. It shows in chain_word[0] at the shift where the run of leading bits should end, so it can surface up to l clocks after the load. A wrong phase flag inverts the first shifted bit of a codeword, and so it is visible one clock after the load. A shifting fault in the register corrupts the higher chain_word bits on the very next clock. The bench therefore compares the whole register after every clock and also rebuilds each codeword from the serial stream.

// File: rtl/scalable_sic_counter.sv
module scalable_sic_counter #(
  parameter int CHAIN_LEN  = 64,
  parameter int NUM_CHAINS = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scan_en,
  output logic [NUM_CHAINS-1:0] chain_word
);
  localparam int KW = (CHAIN_LEN > 1) ? $clog2(CHAIN_LEN) : 1;
  localparam logic [KW-1:0] LAST = KW'(CHAIN_LEN - 1);

  logic [KW-1:0]         run_cnt, run_left;
  logic                  cnt_phase, run_phase;
  logic [NUM_CHAINS-1:0] shreg;
  logic                  fill_bit;

  assign fill_bit   = (run_left != '0) ^ run_phase;
  assign chain_word = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_cnt   <= '0;
      cnt_phase <= 1'b0;
      run_left  <= '0;
      run_phase <= 1'b0;
      shreg     <= '0;
    end else if (!scan_en) begin
      run_left  <= run_cnt;
      run_phase <= cnt_phase;
      if (run_cnt == LAST) begin
        run_cnt   <= '0;
        cnt_phase <= ~cnt_phase;
      end else begin
        run_cnt <= run_cnt + KW'(1);
      end
    end else begin
      shreg <= {shreg[NUM_CHAINS-2:0], fill_bit};
      if (run_left != '0) run_left <= run_left - KW'(1);
    end
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> $stable(chain_word));
  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> (run_left == $past(run_cnt)) && (run_phase == $past(cnt_phase)));
  assert_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> chain_word[NUM_CHAINS-1:1] == $past(chain_word[NUM_CHAINS-2:0]));
  assert_meter_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && run_left != '0) |=> run_left == $past(run_left) - KW'(1));
  assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && run_cnt == LAST) |=> (run_cnt == '0) && (cnt_phase != $past(cnt_phase)));
  assert_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    run_cnt <= LAST);
  assert_tail_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (scan_en && run_left == '0) |=> chain_word[0] == $past(run_phase));
endmodule

// File: tb/scalable_sic_counter_bench.sv
module scalable_sic_counter_bench;
  localparam int L = 64;
  localparam int M = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         scan_en = 1'b0;
  logic [M-1:0] chain_word;

  int errors = 0, checks = 0;
  int nxt_idx = 0, cur_idx = 0, pos = 0;
  logic [M-1:0] exp_reg = '0;
  bit done = 0;

  always #10 clk = ~clk;

  scalable_sic_counter #(.CHAIN_LEN(L), .NUM_CHAINS(M)) u_scalable_sic_counter (
    .clk(clk), .rst_n(rst_n), .scan_en(scan_en), .chain_word(chain_word));

  function automatic logic jbit(input int idx, input int j);
    return ((j < (idx % L)) ? 1'b1 : 1'b0) ^ ((idx >= L) ? 1'b1 : 1'b0);
  endfunction

  function automatic logic [L-1:0] johnson(input int idx);
    logic [L-1:0] s = '0;
    for (int n = 0; n < idx; n++) s = {~s[0], s[L-1:1]};
    return s;
  endfunction

  task automatic check(input string req, input logic [M-1:0] got, input logic [M-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic tick(input logic se);
    string tag;
    scan_en = se;
    @(negedge clk);
    if (!se) begin
      cur_idx = nxt_idx;
      nxt_idx = (nxt_idx + 1) % (2 * L);
      pos = 0;
      check("R2", chain_word, exp_reg);
    end else begin
      exp_reg = {exp_reg[M-2:0], jbit(cur_idx, pos)};
      if (pos >= L) tag = "R7";
      else if (cur_idx >= L) tag = "R5";
      else tag = "R4";
      check("R3", chain_word, exp_reg);
      check(tag, {{(M-1){1'b0}}, chain_word[0]}, {{(M-1){1'b0}}, exp_reg[0]});
      pos++;
    end
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    scan_en = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    nxt_idx = 0; cur_idx = 0; pos = 0; exp_reg = '0;
    check("R1", chain_word, '0);
  endtask

  task automatic full_codeword;
    logic [L-1:0] got = '0;
    int idx;
    tick(1'b0);
    idx = cur_idx;
    for (int j = 0; j < L; j++) begin
      tick(1'b1);
      got = {got[L-2:0], chain_word[0]};
    end
    checks++;
    if (got !== johnson(idx)) begin
      errors++;
      $display("FAIL R8: codeword %0d got %h expected %h", idx, got, johnson(idx));
    end
  endtask

  initial begin
    int unsigned r;
    r = $urandom(32'd1234);
    do_reset();
    for (int j = 0; j < 3; j++) tick(1'b1);
    check("R1", chain_word, '0);
    for (int c = 0; c < 2 * L; c++) full_codeword();
    full_codeword();
    check("R6", {{(M-1){1'b0}}, (cur_idx == 0) ? 1'b1 : 1'b0}, {{(M-1){1'b0}}, 1'b1});
    check("R6", chain_word, '0);
    for (int j = 0; j < 12; j++) tick(1'b1);
    do_reset();
    full_codeword();
    for (int s = 0; s < 300; s++) begin
      int gaps = 1 + ($urandom % 3);
      int len  = $urandom % (L + 9);
      for (int g = 0; g < gaps; g++) tick(1'b0);
      for (int k = 0; k < len; k++) tick(1'b1);
    end
    for (int c = 0; c < 4; c++) full_codeword();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule